// File: doc/BRIEF.md
# Dual-Clock Sequential Line Memory

This block is a line buffer that stores one video line or similar stream of words. It is read back strictly in the order it was written. The write side and the read side each have their own clock and their own asynchronous system reset. Neither side has an address input. Each side keeps a private pointer that moves forward by one word on every enabled clock edge. The pointer jumps back to location zero either when its pointer-reset pin is sampled low, or on its own after the last word.

Both stream interfaces are plain and never apply back-pressure. The write side takes one word on each rising edge of its clock while its active-low enable is low. The read side produces one word, registered, on each rising edge of its clock while its active-low enable is low. There is no ready signal, and no full or empty indication. The user sequences the two sides, normally by starting the read of a line after enough of it has been written. On the read side, an output-enable flag shows whether the data bus is driven. The bus floats during disabled cycles.

After each pointer reset, a port is expected to run a minimum number of active cycles before its next pointer reset. A per-port sticky flag records any run that was too short.

Top module: `lm_line_buffer`

## Requirements
- R1: The memory holds DEPTH words of WIDTH bits (defaults 5048 and 8). Words written in order from location zero are read back unchanged and in the same order.
- R2: On a rising `wclk` edge with `wr_en_n` low, `wr_data` is stored at the write pointer's location, and the write pointer advances by one.
- R3: On a rising `wclk` edge with `wr_en_n` high, nothing is stored and the write pointer keeps its value. A later read of those locations returns their earlier contents.
- R4: When a pointer-reset pin (`wr_ptr_rst_n` or `rd_ptr_rst_n`) is low at its port's rising clock edge, that pointer returns to location zero. It does so whatever the enable is. If the enable is also low on that edge, the edge accesses location zero and the pointer moves on to location one.
- R5: After an enabled access to location DEPTH-1, a pointer continues at location zero without a pointer reset. This holds for both ports.
- R6: On a rising `rclk` edge with `rd_en_n` low, the word at the read pointer appears on `rd_data` after that edge, `rd_oe` is 1, and the read pointer advances by one.
- R7: On a rising `rclk` edge with `rd_en_n` high, the read pointer keeps its value, `rd_oe` goes to 0, and `rd_data` is high-impedance from that edge on.
- R8: After a disabled stretch, the first rising `rclk` edge with `rd_en_n` low sets `rd_oe` back to 1. The output carries the word that follows the last one read.
- R9: The active write edges from a write pointer reset edge (counted if enabled) up to the next one are counted. If that count is below MIN_RUN (default 18), the next write pointer reset sets `wr_short_run`. A count of exactly MIN_RUN does not set it. The first pointer reset after system reset never sets it. The flag stays set until `wrst_n` is asserted.
- R10: `rd_short_run` follows the same rule as R9 for the read port, on `rclk` with `rd_ptr_rst_n` and `rd_en_n`, and is cleared only by `rrst_n`.
- R11: While `wrst_n` and `rrst_n` are low, both pointers are zero, `rd_oe` is 0, and both short-run flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Asynchronous active-low system reset, write side |
| wr_en_n | input | 1 | Active-low write enable |
| wr_ptr_rst_n | input | 1 | Active-low synchronous write pointer restart |
| wr_data | input | WIDTH | Word to store |
| wr_short_run | output | 1 | Sticky flag: a write run was shorter than MIN_RUN |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Asynchronous active-low system reset, read side |
| rd_en_n | input | 1 | Active-low read enable |
| rd_ptr_rst_n | input | 1 | Active-low synchronous read pointer restart |
| rd_data | output | WIDTH | Registered read word; high-impedance while rd_oe is 0 |
| rd_oe | output | 1 | Read output-enable |
| rd_short_run | output | 1 | Sticky flag: a read run was shorter than MIN_RUN |

## Verification
The assertions assume that each port's enable and pointer-reset pins are stable around that port's rising clock edge, and that each system reset is released away from its clock edge. The bench drives all control and data on the falling edge of the clock they belong to, and releases reset there too. The bench keeps the two ports in separate phases, so a word is never read in the same instant it is written. Reads touch only locations already written. Random enable gaps are drawn with a fixed seed. Pointer resets are issued only after at least MIN_RUN active cycles, except in the directed short-run cases.

// File: rtl/lm_pkg.sv
package lm_pkg;
  localparam int unsigned LM_DEPTH   = 5048;
  localparam int unsigned LM_WIDTH   = 8;
  localparam int unsigned LM_MIN_RUN = 18;

  function automatic int unsigned lm_addr_bits(input int unsigned depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction
endpackage

// File: rtl/lm_seq_ptr.sv
module lm_seq_ptr #(
  parameter int unsigned DEPTH = lm_pkg::LM_DEPTH,
  localparam int unsigned AW = lm_pkg::lm_addr_bits(DEPTH)
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          ptr_rst_n,
  input  logic          en_n,
  output logic [AW-1:0] addr_o,
  output logic          fire_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q;

  // A restart edge accesses location zero
  assign addr_o = ptr_rst_n ? ptr_q : '0;
  assign fire_o = !en_n;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)
      ptr_q <= '0;
    else if (!en_n)
      ptr_q <= (addr_o == LAST) ? '0 : addr_o + 1'b1;
    else if (!ptr_rst_n)
      ptr_q <= '0;
  end

  // R3: idle edge leaves the pointer where it was
  p_hold_r3: assert property (@(posedge clk) disable iff (!arst_n)
    (en_n && ptr_rst_n) |=> $stable(ptr_q));

  // R4: restart without access parks the pointer at zero
  p_restart_idle_r4: assert property (@(posedge clk) disable iff (!arst_n)
    (!ptr_rst_n && en_n) |=> (ptr_q == '0));

  // R4: restart with access leaves the pointer one past zero
  p_restart_fire_r4: assert property (@(posedge clk) disable iff (!arst_n)
    (!ptr_rst_n && !en_n) |=> (ptr_q == ((DEPTH > 1) ? AW'(1) : '0)));

  // R5: wrap after the final location
  p_wrap_r5: assert property (@(posedge clk) disable iff (!arst_n)
    (ptr_rst_n && !en_n && ptr_q == LAST) |=> (ptr_q == '0));

  // R1: pointer never leaves the array
  always_comb begin
    if (arst_n) p_in_range_r1: assert (ptr_q <= LAST);
  end
endmodule

// File: rtl/lm_run_guard.sv
module lm_run_guard #(
  parameter int unsigned MIN_RUN = lm_pkg::LM_MIN_RUN,
  localparam int unsigned CW = $clog2(MIN_RUN + 1)
) (
  input  logic clk,
  input  logic arst_n,
  input  logic ptr_rst_n,
  input  logic en_n,
  output logic short_run_o
);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_RUN);

  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic          flag_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
    end else if (!ptr_rst_n) begin
      if (armed_q && cnt_q < LIMIT) flag_q <= 1'b1;
      armed_q <= 1'b1;
      cnt_q   <= en_n ? '0 : CW'(1);
    end else if (!en_n && cnt_q < LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign short_run_o = flag_q;

  // R9 / R10: flag is sticky until system reset
  p_sticky_r9: assert property (@(posedge clk) disable iff (!arst_n)
    flag_q |=> flag_q);

  // R9 / R10: flag only rises on a restart edge
  p_rise_on_restart_r10: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(flag_q) |-> $past(!ptr_rst_n));
endmodule

// File: rtl/lm_dual_ram.sv
module lm_dual_ram #(
  parameter int unsigned DEPTH = lm_pkg::LM_DEPTH,
  parameter int unsigned WIDTH = lm_pkg::LM_WIDTH,
  localparam int unsigned AW = lm_pkg::lm_addr_bits(DEPTH)
) (
  input  logic             wclk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rclk,
  input  logic             rrst_n,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata_o,
  output logic             oe_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] q;
  logic             oe_q;

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      q    <= '0;
      oe_q <= 1'b0;
    end else begin
      oe_q <= re;
      if (re) q <= mem[raddr];
    end
  end

  assign rdata_o = q;
  assign oe_o    = oe_q;

  // R7: a disabled read edge turns the output off
  p_oe_off_r7: assert property (@(posedge rclk) disable iff (!rrst_n)
    !re |=> !oe_q);

  // R8: an enabled read edge turns the output back on
  p_oe_on_r8: assert property (@(posedge rclk) disable iff (!rrst_n)
    re |=> oe_q);

  // R7: held data does not change while the output is off
  p_hold_data_r7: assert property (@(posedge rclk) disable iff (!rrst_n)
    !re |=> $stable(q));
endmodule

// File: rtl/lm_line_buffer.sv
module lm_line_buffer #(
  parameter int unsigned DEPTH   = lm_pkg::LM_DEPTH,
  parameter int unsigned WIDTH   = lm_pkg::LM_WIDTH,
  parameter int unsigned MIN_RUN = lm_pkg::LM_MIN_RUN
) (
  input  logic             wclk,
  input  logic             wrst_n,
  input  logic             wr_en_n,
  input  logic             wr_ptr_rst_n,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_short_run,
  input  logic             rclk,
  input  logic             rrst_n,
  input  logic             rd_en_n,
  input  logic             rd_ptr_rst_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_oe,
  output logic             rd_short_run
);
  localparam int unsigned AW = lm_pkg::lm_addr_bits(DEPTH);

  logic [AW-1:0]    waddr, raddr;
  logic             wfire, rfire;
  logic [WIDTH-1:0] rword;

  lm_seq_ptr #(.DEPTH(DEPTH)) u_wptr (
    .clk(wclk), .arst_n(wrst_n), .ptr_rst_n(wr_ptr_rst_n), .en_n(wr_en_n),
    .addr_o(waddr), .fire_o(wfire));

  lm_seq_ptr #(.DEPTH(DEPTH)) u_rptr (
    .clk(rclk), .arst_n(rrst_n), .ptr_rst_n(rd_ptr_rst_n), .en_n(rd_en_n),
    .addr_o(raddr), .fire_o(rfire));

  lm_run_guard #(.MIN_RUN(MIN_RUN)) u_wguard (
    .clk(wclk), .arst_n(wrst_n), .ptr_rst_n(wr_ptr_rst_n), .en_n(wr_en_n),
    .short_run_o(wr_short_run));

  lm_run_guard #(.MIN_RUN(MIN_RUN)) u_rguard (
    .clk(rclk), .arst_n(rrst_n), .ptr_rst_n(rd_ptr_rst_n), .en_n(rd_en_n),
    .short_run_o(rd_short_run));

  lm_dual_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
    .wclk(wclk), .we(wfire), .waddr(waddr), .wdata(wr_data),
    .rclk(rclk), .rrst_n(rrst_n), .re(rfire), .raddr(raddr),
    .rdata_o(rword), .oe_o(rd_oe));

  assign rd_data = rd_oe ? rword : 'z;
endmodule

// File: tb/tb_lm_line_buffer.sv
module tb_lm_line_buffer;
  localparam int DEPTH = lm_pkg::LM_DEPTH;
  localparam int MINR  = lm_pkg::LM_MIN_RUN;

  logic wclk = 0, rclk = 0;
  logic wrst_n = 0, rrst_n = 0;
  logic wr_en_n = 1, wr_ptr_rst_n = 1, rd_en_n = 1, rd_ptr_rst_n = 1;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic rd_oe, wr_short_run, rd_short_run;

  always #2.5ns wclk = ~wclk;
  initial begin #1.25ns; forever #2.5ns rclk = ~rclk; end

  lm_line_buffer dut (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en_n(wr_en_n), .wr_ptr_rst_n(wr_ptr_rst_n),
    .wr_data(wr_data), .wr_short_run(wr_short_run),
    .rclk(rclk), .rrst_n(rrst_n), .rd_en_n(rd_en_n), .rd_ptr_rst_n(rd_ptr_rst_n),
    .rd_data(rd_data), .rd_oe(rd_oe), .rd_short_run(rd_short_run));

  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] mem_m [DEPTH];
  int wp_m = 0, rp_m = 0;
  int wcnt_m = 0, rcnt_m = 0;
  bit warm_m = 0, rarm_m = 0, wflag_m = 0, rflag_m = 0;
  int written_m = 0;

  function automatic logic [7:0] pat(input int i, input int salt);
    return 8'((i * 7 + salt * 13 + 3) ^ (i >> 8));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_step(input bit prst, input bit en, input logic [7:0] d);
    int a;
    @(negedge wclk);
    wr_ptr_rst_n = !prst; wr_en_n = !en; wr_data = d;
    @(posedge wclk);
    #1ns;
    wr_ptr_rst_n = 1; wr_en_n = 1;
    a = prst ? 0 : wp_m;
    if (prst) begin
      if (warm_m && wcnt_m < MINR) wflag_m = 1;
      warm_m = 1; wcnt_m = 0;
    end
    if (en) begin
      mem_m[a] = d;
      wp_m = (a == DEPTH - 1) ? 0 : a + 1;
      if (wcnt_m < MINR) wcnt_m++;
    end else if (prst) wp_m = 0;
  endtask

  task automatic rd_step(input bit prst, input bit en, input string req);
    int a;
    @(negedge rclk);
    rd_ptr_rst_n = !prst; rd_en_n = !en;
    @(posedge rclk);
    #1ns;
    rd_ptr_rst_n = 1; rd_en_n = 1;
    a = prst ? 0 : rp_m;
    if (prst) begin
      if (rarm_m && rcnt_m < MINR) rflag_m = 1;
      rarm_m = 1; rcnt_m = 0;
    end
    if (en) begin
      chk({req, " R6 oe"}, 32'(rd_oe), 32'd1);
      chk({req, " R6 data"}, 32'(rd_data), 32'(mem_m[a]));
      rp_m = (a == DEPTH - 1) ? 0 : a + 1;
      if (rcnt_m < MINR) rcnt_m++;
    end else begin
      chk({req, " R7 oe off"}, 32'(rd_oe), 32'd0);
      if (prst) rp_m = 0;
    end
  endtask

  initial begin
    #(200000 * 5ns);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n, act;
    void'($urandom(32'h5eed_1a2b));
    for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;

    // R11: reset state
    repeat (4) @(negedge wclk);
    chk("R11 oe", 32'(rd_oe), 0);
    chk("R11 wflag", 32'(wr_short_run), 0);
    chk("R11 rflag", 32'(rd_short_run), 0);
    @(negedge wclk); wrst_n = 1;
    @(negedge rclk); rrst_n = 1;

    // R4/R2/R3: restart with write, then random gaps
    wr_step(1, 1, 8'hA5);
    act = 1;
    while (act < 40) begin
      bit en = ($urandom % 4) != 0;
      wr_step(0, en, 8'($urandom));
      if (en) act++;
    end
    // R1/R6/R7/R8: read back with random gaps
    rd_step(1, 1, "R4 rd restart");
    act = 1;
    while (act < 40) begin
      bit en = ($urandom % 3) != 0;
      rd_step(0, en, "R1 R8 mixed");
      if (en) act++;
    end
    // R4: read restart without access, then re-read from zero
    rd_step(1, 0, "R4 rd restart idle");
    for (int i = 0; i < 20; i++) rd_step(0, 1, "R4 reread");

    // R3: idle writes between restart and data leave memory unchanged
    wr_step(1, 0, 8'hFF);
    for (int i = 0; i < 5; i++) wr_step(0, 0, 8'h3C);
    for (int i = 0; i < 20; i++) wr_step(0, 1, pat(i, 1));
    rd_step(1, 0, "R3 restart");
    for (int i = 0; i < 40; i++) rd_step(0, 1, "R3 idle writes ignored");

    // R5: wrap on both ports
    wr_step(1, 0, 8'h00);
    for (int i = 0; i < DEPTH + 5; i++) wr_step(0, 1, pat(i, 2));
    rd_step(1, 0, "R5 restart");
    for (int i = 0; i < DEPTH + 5; i++) rd_step(0, 1, "R5 wrap");
    chk("R9 no flag after long runs", 32'(wr_short_run), 0);
    chk("R10 no flag after long runs", 32'(rd_short_run), 0);

    // R9: boundary MIN_RUN passes, MIN_RUN-1 flags
    wr_step(1, 0, 8'h00);
    for (int i = 0; i < MINR; i++) wr_step(0, 1, pat(i, 3));
    wr_step(1, 0, 8'h00);
    chk("R9 exact run", 32'(wr_short_run), 32'(wflag_m));
    chk("R9 exact run literal", 32'(wr_short_run), 0);
    for (int i = 0; i < MINR - 1; i++) wr_step(0, 1, pat(i, 4));
    wr_step(1, 0, 8'h00);
    chk("R9 short run", 32'(wr_short_run), 1);
    for (int i = 0; i < 30; i++) wr_step(0, 1, pat(i, 5));
    wr_step(1, 0, 8'h00);
    chk("R9 sticky", 32'(wr_short_run), 32'(wflag_m));

    // R10: same on the read side
    rd_step(1, 0, "R10 restart");
    for (int i = 0; i < MINR; i++) rd_step(0, 1, "R10 run");
    rd_step(1, 0, "R10 restart exact");
    chk("R10 exact run", 32'(rd_short_run), 0);
    for (int i = 0; i < MINR - 1; i++) rd_step(0, 1, "R10 short");
    rd_step(1, 0, "R10 restart short");
    chk("R10 short run", 32'(rd_short_run), 1);
    for (int i = 0; i < 25; i++) rd_step(0, 1, "R10 after");
    chk("R10 sticky", 32'(rd_short_run), 32'(rflag_m));
    n = 0;

    // R11: system reset clears flags and output enable
    @(negedge wclk); wrst_n = 0;
    @(negedge rclk); rrst_n = 0;
    #2ns;
    chk("R11 wflag clear", 32'(wr_short_run), 0);
    chk("R11 rflag clear", 32'(rd_short_run), 0);
    chk("R11 oe clear", 32'(rd_oe), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule